// File: doc/BRIEF.md
# Flash Status-Register Write Sequencer

This block changes the status register of an external serial flash device. A request carries the new status byte. The sequencer first sends a one-byte enable command. It then sends the write-status command with the new byte. After that it waits out the device's self-timed internal cycle by reading the status register until the write-in-progress flag clears. Exactly one outcome pulse ends each request: done, error or timeout.

The block does not shift bits itself. It drives a byte-level frame port to a serial master. Each frame is a single chip-select assertion. A frame has a start pulse, up to two transmit bytes and a receive count. The master answers with a completion pulse, a failure flag and the first received byte.

Which enable opcode is used depends on two capability inputs. When both are set, the block falls back to the alternate opcode if the first attempt fails. All waits are counted in pulses of a microsecond tick input.

Top module: `srw_status_write_seq`

## Requirements
- R1: A `req` pulse while idle captures `new_status` and the capability inputs, and `busy` is high from the next cycle until the outcome pulse. A `req` while busy is ignored: it starts no extra frames, produces no extra outcome, and the captured byte is kept. No frame starts while idle.
- R2: Each attempt opens with a one-byte enable frame that reads nothing. The opcode is 0x06 when `cap_wr_enable` is set. Otherwise it is 0x50, and this includes the case where neither capability input is set.
- R3: If both capability inputs are set and the 0x06 attempt ends in error or timeout, the whole sequence is repeated once with 0x50. The outcome of that second attempt is the one reported.
- R4: After a successful enable frame, a separate write-status frame is sent. It carries two bytes, 0x01 and then the captured status byte, and reads nothing. The first transmit byte sits in `spi_tx_data[15:8]` and the second in `[7:0]`.
- R5: A failed enable or write-status frame (`spi_fail` high with `spi_done`) ends the attempt at once. No further frame of that attempt is sent and no busy-wait is done. If no retry applies, `err` pulses.
- R6: After the write-status frame completes, exactly INIT_WAIT_TICKS tick pulses are counted before the first status-read frame starts. Cycles without a tick do not count.
- R7: A status-read frame sends the single byte 0x05 and receives one byte. Bit 0 of that byte is the write-in-progress flag.
- R8: When a read returns bit 0 set and the poll limit is not yet reached, the block waits exactly POLL_WAIT_TICKS ticks and reads again. A read with bit 0 clear ends the request with `done`.
- R9: If the first read and the MAX_POLLS reads after it all return bit 0 set, the attempt ends in timeout. If no retry applies, `timeout` pulses.
- R10: Each request yields exactly one one-cycle pulse on one of `done`, `err` or `timeout`. `busy` is low in that same cycle.
- R11: A failure flag on a status-read frame is ignored. The returned byte is used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| req | input | 1 | Start a status write |
| new_status | input | 8 | Status byte to write |
| cap_wr_enable | input | 1 | Device accepts write-enable (0x06) before status write |
| cap_sr_enable | input | 1 | Device accepts status-enable (0x50) before status write |
| busy | output | 1 | Request in progress |
| done | output | 1 | Pulse: status written and device idle |
| err | output | 1 | Pulse: a command frame failed |
| timeout | output | 1 | Pulse: device stayed busy past the poll limit |
| spi_start | output | 1 | Pulse: begin one chip-select frame |
| spi_tx_count | output | 2 | Bytes to transmit in the frame |
| spi_tx_data | output | 16 | Transmit bytes, first in [15:8] |
| spi_rx_count | output | 2 | Bytes to receive after transmit |
| spi_done | input | 1 | Pulse: frame finished |
| spi_fail | input | 1 | Frame failed, valid with spi_done |
| spi_rx_byte | input | 8 | First received byte, valid with spi_done |

## Verification
The hardest case to reach is the double fallback. Both capability inputs are set, and the device model keeps reporting busy through the whole poll budget of both attempts. The bench checks that it sees two full timeout sequences with different enable opcodes, and only then a single timeout pulse. A frame model, driven from a vector table, reaches this case together with the enable-failure and read-failure paths. It injects failures per opcode and scripts how many busy reads follow each write-status frame. A monitor measures the tick count between each frame completion and the next read start, so every wait interval is checked to the exact tick.

// File: rtl/srw_pkg.sv
package srw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EN_REQ,
    S_EN_WAIT,
    S_WS_REQ,
    S_WS_WAIT,
    S_DELAY,
    S_RD_REQ,
    S_RD_WAIT
  } srw_state_e;

  localparam logic [7:0] OPC_WR_ENABLE = 8'h06;
  localparam logic [7:0] OPC_SR_ENABLE = 8'h50;
  localparam logic [7:0] OPC_SR_WRITE  = 8'h01;
  localparam logic [7:0] OPC_SR_READ   = 8'h05;

endpackage

// File: rtl/srw_tick_timer.sv
module srw_tick_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         act_q, act_d;

  // Fires on the tick that consumes the last remaining count.
  assign expired = act_q && tick && (cnt_q == W'(1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = load_val;
      act_d = 1'b1;
    end else if (act_q && tick) begin
      cnt_d = cnt_q - W'(1);
      act_d = (cnt_q != W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/srw_frame_builder.sv
module srw_frame_builder
  import srw_pkg::*;
(
  input  srw_state_e  state,
  input  logic        use_sr_enable,
  input  logic [7:0]  status_byte,
  output logic        start,
  output logic [1:0]  tx_count,
  output logic [15:0] tx_data,
  output logic [1:0]  rx_count
);

  always_comb begin
    start    = 1'b0;
    tx_count = 2'd0;
    tx_data  = 16'h0000;
    rx_count = 2'd0;
    unique case (state)
      S_EN_REQ: begin
        start    = 1'b1;
        tx_count = 2'd1;
        tx_data  = {(use_sr_enable ? OPC_SR_ENABLE : OPC_WR_ENABLE), 8'h00};
      end
      S_WS_REQ: begin
        start    = 1'b1;
        tx_count = 2'd2;
        tx_data  = {OPC_SR_WRITE, status_byte};
      end
      S_RD_REQ: begin
        start    = 1'b1;
        tx_count = 2'd1;
        tx_data  = {OPC_SR_READ, 8'h00};
        rx_count = 2'd1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/srw_status_write_seq.sv
module srw_status_write_seq
  import srw_pkg::*;
#(
  parameter int unsigned INIT_WAIT_TICKS = 100000,
  parameter int unsigned POLL_WAIT_TICKS = 10000,
  parameter int unsigned MAX_POLLS       = 490
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_us,
  input  logic        req,
  input  logic [7:0]  new_status,
  input  logic        cap_wr_enable,
  input  logic        cap_sr_enable,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        timeout,
  output logic        spi_start,
  output logic [1:0]  spi_tx_count,
  output logic [15:0] spi_tx_data,
  output logic [1:0]  spi_rx_count,
  input  logic        spi_done,
  input  logic        spi_fail,
  input  logic [7:0]  spi_rx_byte
);

  localparam int unsigned TMAX = (INIT_WAIT_TICKS > POLL_WAIT_TICKS) ?
                                 INIT_WAIT_TICKS : POLL_WAIT_TICKS;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned PW   = $clog2(MAX_POLLS + 1);

  srw_state_e    state_q, state_d;
  logic          use_sr_q, use_sr_d;
  logic          retry_ok_q;
  logic [7:0]    status_q;
  logic [PW-1:0] polls_q, polls_d;
  logic          done_q, err_q, to_q;

  logic          capture, use_sr_en, polls_en;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          fin_done, fin_err, fin_to;
  logic          att_fail, fail_is_to;

  srw_tick_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick_us),
    .expired  (tmr_exp)
  );

  srw_frame_builder u_frame (
    .state         (state_q),
    .use_sr_enable (use_sr_q),
    .status_byte   (status_q),
    .start         (spi_start),
    .tx_count      (spi_tx_count),
    .tx_data       (spi_tx_data),
    .rx_count      (spi_rx_count)
  );

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    use_sr_d   = use_sr_q;
    polls_d    = polls_q;
    capture    = 1'b0;
    use_sr_en  = 1'b0;
    polls_en   = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = TW'(POLL_WAIT_TICKS);
    fin_done   = 1'b0;
    fin_err    = 1'b0;
    fin_to     = 1'b0;
    att_fail   = 1'b0;
    fail_is_to = 1'b0;

    unique case (state_q)
      S_IDLE: if (req) begin
        capture   = 1'b1;
        use_sr_en = 1'b1;
        use_sr_d  = !cap_wr_enable;
        state_d   = S_EN_REQ;
      end
      S_EN_REQ:  state_d = S_EN_WAIT;
      S_EN_WAIT: if (spi_done) begin
        if (spi_fail) att_fail = 1'b1;
        else          state_d  = S_WS_REQ;
      end
      S_WS_REQ:  state_d = S_WS_WAIT;
      S_WS_WAIT: if (spi_done) begin
        if (spi_fail) att_fail = 1'b1;
        else begin
          tmr_load = 1'b1;
          tmr_val  = TW'(INIT_WAIT_TICKS);
          polls_en = 1'b1;
          polls_d  = '0;
          state_d  = S_DELAY;
        end
      end
      S_DELAY:   if (tmr_exp) state_d = S_RD_REQ;
      S_RD_REQ:  state_d = S_RD_WAIT;
      S_RD_WAIT: if (spi_done) begin
        if (!spi_rx_byte[0]) begin
          fin_done = 1'b1;
          state_d  = S_IDLE;
        end else if (polls_q == PW'(MAX_POLLS)) begin
          att_fail   = 1'b1;
          fail_is_to = 1'b1;
        end else begin
          polls_en = 1'b1;
          polls_d  = polls_q + PW'(1);
          tmr_load = 1'b1;
          state_d  = S_DELAY;
        end
      end
      default:   state_d = S_IDLE;
    endcase

    if (att_fail) begin
      if (retry_ok_q && !use_sr_q) begin
        use_sr_en = 1'b1;
        use_sr_d  = 1'b1;
        state_d   = S_EN_REQ;
      end else begin
        state_d = S_IDLE;
        fin_err = !fail_is_to;
        fin_to  = fail_is_to;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      use_sr_q   <= 1'b0;
      retry_ok_q <= 1'b0;
      status_q   <= 8'h00;
      polls_q    <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        status_q   <= new_status;
        retry_ok_q <= cap_wr_enable && cap_sr_enable;
      end
      if (use_sr_en) use_sr_q <= use_sr_d;
      if (polls_en)  polls_q  <= polls_d;
      done_q <= fin_done;
      err_q  <= fin_err;
      to_q   <= fin_to;
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign timeout = to_q;

endmodule

// File: rtl/srw_seq_checker.sv
module srw_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       timeout,
  input logic       spi_start,
  input logic [1:0] spi_tx_count,
  input logic [7:0] first_byte,
  input logic [1:0] spi_rx_count
);

  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy); // R1

  AST_NO_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_start); // R1

  AST_ENABLE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && spi_tx_count == 2'd1 && spi_rx_count == 2'd0) |->
    (first_byte == 8'h06 || first_byte == 8'h50)); // R2

  AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && spi_tx_count == 2'd2) |->
    (first_byte == 8'h01 && spi_rx_count == 2'd0)); // R4

  AST_SEPARATE_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start); // R4

  AST_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_start && spi_rx_count != 2'd0) |->
    (spi_tx_count == 2'd1 && spi_rx_count == 2'd1 && first_byte == 8'h05)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, timeout})); // R10

  AST_OUTCOME_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err || timeout) |-> (!busy && $past(busy))); // R10

endmodule

bind srw_status_write_seq srw_seq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .timeout      (timeout),
  .spi_start    (spi_start),
  .spi_tx_count (spi_tx_count),
  .first_byte   (spi_tx_data[15:8]),
  .spi_rx_count (spi_rx_count)
);

// File: tb/tb_srw_status_write_seq.sv
module tb_srw_status_write_seq;

  localparam int INIT = 12;
  localparam int POLL = 5;
  localparam int MAXP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_us;
  logic        req;
  logic [7:0]  new_status;
  logic        cap_wr_enable, cap_sr_enable;
  logic        busy, done, err, timeout;
  logic        spi_start;
  logic [1:0]  spi_tx_count, spi_rx_count;
  logic [15:0] spi_tx_data;
  logic        spi_done, spi_fail;
  logic [7:0]  spi_rx_byte;

  always #10 clk = ~clk;

  srw_status_write_seq #(
    .INIT_WAIT_TICKS (INIT),
    .POLL_WAIT_TICKS (POLL),
    .MAX_POLLS       (MAXP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .tick_us (tick_us), .req (req),
    .new_status (new_status), .cap_wr_enable (cap_wr_enable),
    .cap_sr_enable (cap_sr_enable), .busy (busy), .done (done), .err (err),
    .timeout (timeout), .spi_start (spi_start), .spi_tx_count (spi_tx_count),
    .spi_tx_data (spi_tx_data), .spi_rx_count (spi_rx_count),
    .spi_done (spi_done), .spi_fail (spi_fail), .spi_rx_byte (spi_rx_byte)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Device scenario, set per test
  bit cur_fw, cur_fe, cur_fr;
  int cur_busy;          // busy reads after each status write; 15 = forever

  // Observations
  int n_en, n_ws, n_rd, n_res, res_code;
  bit res_busy;
  logic [7:0] first_en, last_en, ws_data;

  // Frame model and tick source: drives just after each rising edge
  int sl_wait, sl_kind, busy_left, tick_div;
  logic [7:0] sl_op;
  always @(posedge clk) begin
    #1;
    tick_div = (tick_div >= 2) ? 0 : tick_div + 1;
    tick_us  = (tick_div == 0);
    spi_done = 1'b0;
    spi_fail = 1'b0;
    if (!rst_n) begin
      sl_wait = 0;
    end else if (sl_wait > 0) begin
      sl_wait--;
      if (sl_wait == 0) begin
        spi_done = 1'b1;
        if (sl_kind == 1)
          spi_fail = (sl_op == 8'h06 && cur_fw) || (sl_op == 8'h50 && cur_fe);
        if (sl_kind == 3) begin
          spi_rx_byte = {7'h00, busy_left > 0};
          if (busy_left > 0 && busy_left != 15) busy_left--;
          spi_fail = cur_fr;
        end
      end
    end else if (spi_start) begin
      sl_op   = spi_tx_data[15:8];
      sl_wait = 2;
      if (spi_rx_count == 2'd1) begin
        sl_kind = 3; n_rd++;
      end else if (spi_tx_count == 2'd2) begin
        sl_kind = 2; n_ws++; ws_data = spi_tx_data[7:0]; busy_left = cur_busy;
      end else begin
        sl_kind = 1; n_en++; last_en = sl_op;
        if (n_en == 1) first_en = sl_op;
      end
    end
  end

  // Monitor: outcomes and tick intervals between frame end and next read
  bit mon_on = 1'b0;
  int mon_cnt, mon_exp;
  always @(negedge clk) begin
    if (rst_n && (done || err || timeout)) begin
      n_res++;
      res_code = timeout ? 3 : (err ? 2 : 1);
      res_busy = busy;
    end
    if (mon_on) begin
      if (spi_start) begin
        mon_on = 1'b0;
        if (spi_rx_count == 2'd1)
          chk(mon_cnt == mon_exp, (mon_exp == INIT) ? "R6" : "R8",
              "ticks before read", mon_cnt, mon_exp);
      end else if (tick_us) mon_cnt++;
    end
    if (spi_done && sl_kind == 2 && !spi_fail) begin
      mon_on = 1'b1; mon_cnt = 0; mon_exp = INIT;
    end
    if (spi_done && sl_kind == 3 && spi_rx_byte[0]) begin
      mon_on = 1'b1; mon_cnt = 0; mon_exp = POLL;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] caps;   // [1]=wr_enable, [0]=sr_enable
    logic       fw;     // fail 0x06 frame
    logic       fe;     // fail 0x50 frame
    logic       fr;     // fail flag on read frames
    logic [3:0] bsy;
    logic [1:0] res;    // 1 done, 2 err, 3 timeout
    logic [1:0] ens;
    logic [7:0] first;
    logic [7:0] last;
    logic [1:0] ws;
    logic [3:0] rds;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b10, 1'b0, 1'b0, 1'b0, 4'd0,  2'd1, 2'd1, 8'h06, 8'h06, 2'd1, 4'd1}, // R2
    '{2'b01, 1'b0, 1'b0, 1'b0, 4'd2,  2'd1, 2'd1, 8'h50, 8'h50, 2'd1, 4'd3}, // R8
    '{2'b00, 1'b0, 1'b0, 1'b0, 4'd1,  2'd1, 2'd1, 8'h50, 8'h50, 2'd1, 4'd2}, // R2
    '{2'b11, 1'b0, 1'b0, 1'b0, 4'd0,  2'd1, 2'd1, 8'h06, 8'h06, 2'd1, 4'd1}, // R3
    '{2'b11, 1'b1, 1'b0, 1'b0, 4'd0,  2'd1, 2'd2, 8'h06, 8'h50, 2'd1, 4'd1}, // R3
    '{2'b10, 1'b1, 1'b0, 1'b0, 4'd0,  2'd2, 2'd1, 8'h06, 8'h06, 2'd0, 4'd0}, // R5
    '{2'b01, 1'b0, 1'b0, 1'b0, 4'd15, 2'd3, 2'd1, 8'h50, 8'h50, 2'd1, 4'd4}, // R9
    '{2'b11, 1'b0, 1'b0, 1'b0, 4'd15, 2'd3, 2'd2, 8'h06, 8'h50, 2'd2, 4'd8}, // R3 R9
    '{2'b11, 1'b1, 1'b1, 1'b0, 4'd0,  2'd2, 2'd2, 8'h06, 8'h50, 2'd0, 4'd0}, // R5
    '{2'b01, 1'b0, 1'b0, 1'b0, 4'd3,  2'd1, 2'd1, 8'h50, 8'h50, 2'd1, 4'd4}, // R9 edge
    '{2'b01, 1'b0, 1'b0, 1'b1, 4'd1,  2'd1, 2'd1, 8'h50, 8'h50, 2'd1, 4'd2}, // R11
    '{2'b01, 1'b0, 1'b1, 1'b0, 4'd0,  2'd2, 2'd1, 8'h50, 8'h50, 2'd0, 4'd0}  // R5
  };

  task automatic clear_obs();
    n_en = 0; n_ws = 0; n_rd = 0; n_res = 0; res_code = 0;
  endtask

  task automatic wait_outcome();
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      if (n_res > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req = 1'b0; new_status = 8'h00;
    cap_wr_enable = 1'b0; cap_sr_enable = 1'b0;
    tick_us = 1'b0; tick_div = 0; spi_done = 1'b0; spi_fail = 1'b0;
    spi_rx_byte = 8'h00; sl_wait = 0; sl_kind = 0; busy_left = 0;
    cur_fw = 0; cur_fe = 0; cur_fr = 0; cur_busy = 0;
    clear_obs();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(spi_start == 1'b0, "R1", "start in reset", spi_start, 0);
    chk({done, err, timeout} == 3'b000, "R10", "outcome in reset",
        {done, err, timeout}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cur_fw = VEC[i].fw; cur_fe = VEC[i].fe; cur_fr = VEC[i].fr;
      cur_busy = int'(VEC[i].bsy);
      clear_obs();
      @(negedge clk);
      cap_wr_enable = VEC[i].caps[1];
      cap_sr_enable = VEC[i].caps[0];
      new_status = 8'hA0 + 8'(i);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, "R1", $sformatf("v%0d busy after req", i), busy, 1);
      wait_outcome();
      chk(res_code == int'(VEC[i].res), "R10", $sformatf("v%0d outcome", i),
          res_code, VEC[i].res);
      chk(n_res == 1, "R10", $sformatf("v%0d outcome count", i), n_res, 1);
      chk(res_busy == 1'b0, "R10", $sformatf("v%0d busy at outcome", i),
          res_busy, 0);
      chk(n_en == int'(VEC[i].ens), "R3", $sformatf("v%0d enable frames", i),
          n_en, VEC[i].ens);
      chk(first_en == VEC[i].first, "R2", $sformatf("v%0d first opcode", i),
          first_en, VEC[i].first);
      chk(last_en == VEC[i].last, "R3", $sformatf("v%0d last opcode", i),
          last_en, VEC[i].last);
      chk(n_ws == int'(VEC[i].ws), "R5", $sformatf("v%0d write frames", i),
          n_ws, VEC[i].ws);
      if (VEC[i].ws != 0)
        chk(ws_data == 8'hA0 + 8'(i), "R4", $sformatf("v%0d status byte", i),
            ws_data, 8'hA0 + i);
      chk(n_rd == int'(VEC[i].rds), "R7", $sformatf("v%0d read frames", i),
          n_rd, VEC[i].rds);
    end

    // R1: request while busy is ignored
    cur_fw = 0; cur_fe = 0; cur_fr = 0; cur_busy = 1;
    clear_obs();
    @(negedge clk);
    cap_wr_enable = 1'b0; cap_sr_enable = 1'b1;
    new_status = 8'h3C; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    new_status = 8'hFF; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_outcome();
    chk(ws_data == 8'h3C, "R1", "byte kept after busy req", ws_data, 8'h3C);
    chk(n_ws == 1, "R1", "write frames after busy req", n_ws, 1);
    repeat (40) @(negedge clk);
    chk(n_res == 1, "R1", "outcomes after busy req", n_res, 1);
    chk(n_en == 1, "R1", "enable frames after busy req", n_en, 1);
    chk(busy == 1'b0, "R1", "idle after busy req", busy, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule